// File: doc/BRIEF.md
# Two-Cycle Barrett CRC Update Unit

This block advances a reflected CRC register value by 8, 16 or 32 bits in one operation. The caller has already merged the message bits into the low end of the operand. The unit then folds those low bits back through one of two fixed generator polynomials and returns the new 32-bit CRC state. The two generators are the common Ethernet/zip CRC-32 and the Castagnoli CRC-32C.

The block does not step bit by bit. It uses Barrett reduction. The low bits of the operand, moved to the top of the word, are multiplied carry-lessly by a precomputed reciprocal constant. The top part of that product is the quotient. The quotient is then multiplied carry-lessly by the polynomial. The two multiplications run in consecutive clock cycles through one shared carry-less multiplier, and only the low half of each product is formed. The unit holds the result and raises a one-cycle done flag. A new operation can start in the same cycle as that flag.

Top module: `crc_barrett_unit`

## Requirements
- R1: While reset is high and on the first cycle after it, `done_o` is 0 and `result_o` is 0.
- R2: With `poly_sel_i` = 0 the result equals n iterations of x = (x >> 1) ^ (0xEDB88320 & -(x & 1)), starting from x = operand.
- R3: With `poly_sel_i` = 1 the result equals the same n-step iteration using the constant 0x82F63B78.
- R4: `size_i` picks n: 2'b00 gives 8, 2'b01 gives 16, and both 2'b10 and 2'b11 give 32.
- R5: A start accepted in cycle c produces a single-cycle `done_o` in cycle c+2. `result_o` takes the new value in that same cycle.
- R6: A start asserted in the cycle right after an accepted start is ignored. It produces no extra done pulse, and the pending result belongs to the first request.
- R7: `result_o` keeps its value in every cycle where `done_o` is low.
- R8: A start asserted in the cycle where `done_o` is high is accepted. Holding start high therefore yields one result every two cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request strobe, accepted when the unit is idle |
| operand_i | input | 32 | CRC state with message bits already merged into its low end |
| poly_sel_i | input | 1 | 0: CRC-32, 1: CRC-32C |
| size_i | input | 2 | Step width: 00 byte, 01 half-word, 10/11 word |
| result_o | output | 32 | Updated CRC state, registered |
| done_o | output | 1 | One-cycle flag marking a new result |

## Verification
The bench builds the unit with its default 32-bit width and the two standard reflected generators. The reciprocal and normal-form constants are derived at elaboration from those defaults, so a wrong derivation shows up as a result mismatch on the first operation. The bench runs every polynomial and size code against fixed and pseudo-random operands. These include all-zero, all-one and single-bit values, which exercise the edges of the quotient. It also holds start high continuously and injects starts during the busy cycle, which covers the acceptance rules and the throughput limit.

// File: rtl/crc_barrett_pkg.sv
package crc_barrett_pkg;

  localparam int CRC_W = 32;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10,
    SZ_WALT = 2'b11
  } crc_size_e;

  function automatic logic [CRC_W-1:0] bit_rev(input logic [CRC_W-1:0] v);
    logic [CRC_W-1:0] r;
    for (int i = 0; i < CRC_W; i++) r[i] = v[CRC_W-1-i];
    return r;
  endfunction

  // Quotient of x^(2W) by the full generator {1, P}; returns the bit
  // reversal of the quotient with its lowest bit shifted out.
  function automatic logic [CRC_W-1:0] recip_rev(input logic [CRC_W-1:0] poly_refl);
    logic [2*CRC_W:0] num;
    logic [2*CRC_W:0] gen;
    logic [CRC_W:0]   quo;
    num = '0;
    num[2*CRC_W] = 1'b1;
    gen = '0;
    gen[CRC_W:0] = {1'b1, bit_rev(poly_refl)};
    quo = '0;
    for (int i = 2*CRC_W; i >= CRC_W; i--) begin
      if (num[i]) begin
        num = num ^ (gen << (i - CRC_W));
        quo[i-CRC_W] = 1'b1;
      end
    end
    return bit_rev(quo[CRC_W:1]);
  endfunction

endpackage

// File: rtl/crc_clmul_lo.sv
module crc_clmul_lo #(
  parameter int W = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] p_o
);

  logic [W-1:0] rows [W];

  for (genvar g = 0; g < W; g++) begin : g_row
    assign rows[g] = b_i[g] ? (a_i << g) : '0;
  end

  always_comb begin
    p_o = '0;
    for (int i = 0; i < W; i++) p_o = p_o ^ rows[i];
  end

endmodule

// File: rtl/crc_const_sel.sv
module crc_const_sel
  import crc_barrett_pkg::*;
#(
  parameter logic [CRC_W-1:0] POLY0_REFL = 32'hEDB88320,
  parameter logic [CRC_W-1:0] POLY1_REFL = 32'h82F63B78
) (
  input  logic             sel_i,
  output logic [CRC_W-1:0] recip_o,
  output logic [CRC_W-1:0] poly_o
);

  localparam int NPOLY = 2;
  localparam logic [CRC_W-1:0] REFL [NPOLY] = '{POLY0_REFL, POLY1_REFL};

  logic [CRC_W-1:0] recip_tab [NPOLY];
  logic [CRC_W-1:0] poly_tab  [NPOLY];

  for (genvar g = 0; g < NPOLY; g++) begin : g_const
    localparam logic [CRC_W-1:0] RECIP = recip_rev(REFL[g]);
    localparam logic [CRC_W-1:0] NORM  = bit_rev(REFL[g]);
    assign recip_tab[g] = RECIP;
    assign poly_tab[g]  = NORM;
  end

  assign recip_o = recip_tab[sel_i];
  assign poly_o  = poly_tab[sel_i];

endmodule

// File: rtl/crc_operand_prep.sv
module crc_operand_prep
  import crc_barrett_pkg::*;
(
  input  logic [CRC_W-1:0] operand_i,
  input  logic [1:0]       size_i,
  output logic [CRC_W-1:0] top_o,
  output logic [CRC_W-1:0] tail_o
);

  localparam int BW = CRC_W / 4;
  localparam int HW = CRC_W / 2;

  always_comb begin
    unique case (crc_size_e'(size_i))
      SZ_BYTE: begin
        top_o  = operand_i << (CRC_W - BW);
        tail_o = operand_i >> BW;
      end
      SZ_HALF: begin
        top_o  = operand_i << (CRC_W - HW);
        tail_o = operand_i >> HW;
      end
      default: begin
        top_o  = operand_i;
        tail_o = '0;
      end
    endcase
  end

endmodule

// File: rtl/crc_barrett_unit.sv
module crc_barrett_unit
  import crc_barrett_pkg::*;
#(
  parameter logic [CRC_W-1:0] POLY0_REFL = 32'hEDB88320,
  parameter logic [CRC_W-1:0] POLY1_REFL = 32'h82F63B78
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             start_i,
  input  logic [CRC_W-1:0] operand_i,
  input  logic             poly_sel_i,
  input  logic [1:0]       size_i,
  output logic [CRC_W-1:0] result_o,
  output logic             done_o
);

  logic             busy_q;
  logic             sel_q;
  logic [CRC_W-1:0] quot_q;
  logic [CRC_W-1:0] tail_q;
  logic [CRC_W-1:0] result_q;
  logic             done_q;

  logic             sel_eff;
  logic [CRC_W-1:0] recip, poly_norm;
  logic [CRC_W-1:0] top, tail;
  logic [CRC_W-1:0] mul_a, mul_b, prod;
  logic             accept;

  assign accept  = start_i && !busy_q;
  assign sel_eff = busy_q ? sel_q : poly_sel_i;

  crc_const_sel #(
    .POLY0_REFL(POLY0_REFL),
    .POLY1_REFL(POLY1_REFL)
  ) u_const (
    .sel_i  (sel_eff),
    .recip_o(recip),
    .poly_o (poly_norm)
  );

  crc_operand_prep u_prep (
    .operand_i(operand_i),
    .size_i   (size_i),
    .top_o    (top),
    .tail_o   (tail)
  );

  // One multiplier shared by both phases.
  always_comb begin
    mul_a = busy_q ? quot_q    : top;
    mul_b = busy_q ? poly_norm : recip;
  end

  crc_clmul_lo #(.W(CRC_W)) u_clmul (
    .a_i(mul_a),
    .b_i(mul_b),
    .p_o(prod)
  );

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      busy_q   <= 1'b0;
      sel_q    <= 1'b0;
      quot_q   <= '0;
      tail_q   <= '0;
      result_q <= '0;
      done_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (busy_q) begin
        busy_q   <= 1'b0;
        result_q <= tail_q ^ bit_rev(prod);
        done_q   <= 1'b1;
      end else if (accept) begin
        busy_q <= 1'b1;
        sel_q  <= poly_sel_i;
        quot_q <= bit_rev(prod);
        tail_q <= tail;
      end
    end
  end

  assign result_o = result_q;
  assign done_o   = done_q;

endmodule

// File: rtl/crc_barrett_unit_chk.sv
module crc_barrett_unit_chk (
  input logic        clk_i,
  input logic        rst_i,
  input logic        start_i,
  input logic        busy_i,
  input logic [31:0] result_i,
  input logic        done_i
);

  // R5: accepted start gives done two cycles later
  a_r5_done_latency: assert property (@(posedge clk_i) disable iff (rst_i)
    (start_i && !busy_i) |-> ##2 done_i);

  // R5: done is a single-cycle pulse
  a_r5_done_pulse: assert property (@(posedge clk_i) disable iff (rst_i)
    done_i |=> !done_i);

  // R6: busy phase always finishes in one cycle, whatever start does
  a_r6_busy_finishes: assert property (@(posedge clk_i) disable iff (rst_i)
    busy_i |=> (done_i && !busy_i));

  // R6: a start during busy is not taken
  a_r6_no_accept: assert property (@(posedge clk_i) disable iff (rst_i)
    (start_i && busy_i) |=> !busy_i);

  // R7: result holds outside done cycles
  a_r7_result_hold: assert property (@(posedge clk_i) disable iff (rst_i)
    !done_i |-> $stable(result_i));

endmodule

bind crc_barrett_unit crc_barrett_unit_chk u_chk (
  .clk_i   (clk_i),
  .rst_i   (rst_i),
  .start_i (start_i),
  .busy_i  (busy_q),
  .result_i(result_o),
  .done_i  (done_o)
);

// File: tb/crc_barrett_unit_tb_top.sv
`timescale 1ns/1ps
module crc_barrett_unit_tb_top;

  logic        clk = 1'b0;
  logic        rst;
  logic        start;
  logic [31:0] operand;
  logic        sel;
  logic [1:0]  size;
  logic [31:0] result;
  logic        done;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;
  bit scoreboard_on = 0;
  string cur_req = "R2";

  always #2 clk = ~clk;

  crc_barrett_unit dut_i (
    .clk_i     (clk),
    .rst_i     (rst),
    .start_i   (start),
    .operand_i (operand),
    .poly_sel_i(sel),
    .size_i    (size),
    .result_o  (result),
    .done_o    (done)
  );

  function automatic logic [31:0] ref_crc(logic [31:0] x, logic s, logic [1:0] sz);
    logic [31:0] p;
    int n;
    p = s ? 32'h82F63B78 : 32'hEDB88320;
    n = (sz == 2'b00) ? 8 : (sz == 2'b01) ? 16 : 32;
    for (int i = 0; i < n; i++) x = (x >> 1) ^ (p & {32{x[0]}});
    return x;
  endfunction

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%08h expected=%08h at %0t", req, act, exp, $time);
    end
  endtask

  // Behavioural model, advanced on every rising edge
  bit          m_busy = 0;
  bit          m_done = 0;
  logic [31:0] m_pend = '0;
  logic [31:0] m_res  = '0;
  logic [31:0] m_prev = '0;

  always @(posedge clk) begin
    if (rst) begin
      m_busy = 0; m_done = 0; m_res = '0; m_pend = '0;
    end else begin
      m_done = m_busy;
      if (m_busy) begin
        m_res  = m_pend;
        m_busy = 0;
      end else if (start) begin
        m_pend = ref_crc(operand, sel, size);
        m_busy = 1;
      end
    end
  end

  always @(negedge clk) begin
    if (scoreboard_on && !rst) begin
      check(done == m_done, "R5", {31'd0, done}, {31'd0, m_done});
      if (m_done) check(result == m_res, cur_req, result, m_res);
      else        check(result == m_prev, "R7", result, m_prev);
      m_prev = result;
    end
  end

  task automatic drive(bit st, logic [31:0] op, logic s, logic [1:0] sz);
    @(negedge clk);
    start = st; operand = op; sel = s; size = sz;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog R5 actual=%08h expected=%08h", 0, 1);
    finish_run();
  end

  logic [31:0] lcg = 32'h1234_5678;
  logic [31:0] ops [6];

  initial begin
    rst = 1; start = 0; operand = '0; sel = 0; size = 0;
    repeat (4) @(negedge clk);
    // R1: outputs during reset
    check(done == 1'b0, "R1", {31'd0, done}, 32'd0);
    check(result == 32'd0, "R1", result, 32'd0);
    rst = 0;
    @(negedge clk);
    check(done == 1'b0, "R1", {31'd0, done}, 32'd0);
    check(result == 32'd0, "R1", result, 32'd0);
    m_prev = result;
    scoreboard_on = 1;

    ops[0] = 32'h0000_0000; ops[1] = 32'hFFFF_FFFF; ops[2] = 32'h0000_0001;
    ops[3] = 32'h8000_0000; ops[4] = 32'hFFFF_FF9E; ops[5] = 32'hA5A5_5A5A;

    // R2 / R3 / R4: isolated requests over every poly and size code
    for (int s = 0; s < 2; s++) begin
      for (int z = 0; z < 4; z++) begin
        for (int k = 0; k < 10; k++) begin
          logic [31:0] op;
          cur_req = (z == 3 || z == 1) ? "R4" : (s == 0 ? "R2" : "R3");
          if (k < 6) op = ops[k];
          else begin lcg = lcg * 32'd1664525 + 32'd1013904223; op = lcg; end
          drive(1, op, s[0], z[1:0]);
          drive(0, '0, 0, 0);
          drive(0, '0, 0, 0);
        end
      end
    end

    // R6: start held during busy cycle with a different operand
    cur_req = "R6";
    for (int k = 0; k < 20; k++) begin
      lcg = lcg * 32'd1664525 + 32'd1013904223;
      drive(1, lcg, lcg[3], lcg[5:4]);
      drive(1, ~lcg, ~lcg[3], lcg[7:6]);
      drive(0, '0, 0, 0);
      drive(0, '0, 0, 0);
    end

    // R8: start held continuously, new operand each cycle
    cur_req = "R8";
    for (int k = 0; k < 80; k++) begin
      lcg = lcg * 32'd1664525 + 32'd1013904223;
      drive(1, lcg, lcg[9], lcg[12:11]);
    end
    drive(0, '0, 0, 0);
    repeat (4) @(negedge clk);
    finish_run();
  end

endmodule